// File: doc/BRIEF.md
# Receive FIFO with Character Timeout

This block holds received characters for a 16550-style serial port between the receiver and the host. A receiver hands it one byte per strobe, or a break event, and the host drains it one byte per receive-buffer read. The block keeps the line-status flags for data ready, break and overrun, decides whether the fill level has reached the programmed trigger level, and raises a character-timeout flag when data has sat in the queue for four character times. It also offers a single-byte holding mode for when the queue is switched off.

The FIFO control write port selects queued or single-byte mode, the trigger level, and flushes. The bit-time tick and the frame settings (word length, parity enable, stop bits) set how long a character time lasts. A change of mode flushes the receive side and sends a one-cycle flush request to the transmit side.

The read data port shows the oldest held byte, or zero when nothing is held. A read strobe sampled at a clock edge consumes that byte. All flags and counts are registered, so they change one cycle after the strobe that causes them.

Top module: `rx_fifo_tmo`

## Requirements
- R1: After reset, st_ready, st_break, st_overrun, fifo_on, char_timeout, level_hit and txq_flush are 0. fill_count is 0 and rbr_data reads 0.
- R2: With fifo_on = 1 (FIFO control bit 0 written as 1), bytes come out in the order they arrived, up to 16 of them. rbr_data shows the oldest byte, or 0 when the queue is empty. A read of an empty queue changes no state.
- R3: When the queue is full, an incoming byte is dropped, the stored bytes are kept, and st_overrun is set. A push and a read in the same cycle on a full queue store the new byte and do not set overrun.
- R4: FIFO control bits 7:6 set the trigger level: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14. In FIFO mode level_hit is fill_count >= level. In single-byte mode level_hit equals st_ready.
- R5: With fifo_on = 0, one byte is held. A byte that arrives while st_ready = 1 and no read is taking place replaces the held byte and sets st_overrun.
- R6: A break (rx_brk) stores a zero byte and sets st_break and st_ready. It sets st_overrun when there is no room.
- R7: An lsr_rd clears st_break and st_overrun. A break or overrun event in the same cycle wins.
- R8: A read that leaves no data behind clears st_ready and st_break.
- R9: Each push, and each read that leaves data behind, restarts a timeout of 4 character times. These are counted in bit_tick pulses. A character time is 1 start bit, plus 5 + frm_wlen data bits (wlen 00 to 11 gives 5 to 8), plus 1 if frm_par_en, plus 1 stop bit (2 if frm_stop2). When the timeout expires with data still queued, char_timeout is set.
- R10: Any read that takes a byte in FIFO mode clears char_timeout.
- R11: A FIFO control write with bit 1 set empties the receive side. It clears st_ready, st_break and char_timeout and leaves st_overrun alone. A push or read in the same cycle is ignored.
- R12: A FIFO control write that changes bit 0 acts as a receive flush and pulses txq_flush for one cycle. A write with bit 2 set also pulses txq_flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Receiver delivers rx_byte |
| rx_byte | input | DATA_W | Received byte |
| rx_brk | input | 1 | Receiver detected a break |
| rbr_rd | input | 1 | Host reads the receive buffer |
| lsr_rd | input | 1 | Host reads the line status |
| fcr_we | input | 1 | Host writes FIFO control |
| fcr_wdata | input | 8 | FIFO control value |
| bit_tick | input | 1 | One pulse per bit time |
| frm_wlen | input | 2 | Word length code |
| frm_par_en | input | 1 | Parity bit present |
| frm_stop2 | input | 1 | Two stop bits |
| rbr_data | output | DATA_W | Oldest held byte, 0 when none |
| st_ready | output | 1 | Data ready |
| st_break | output | 1 | Break seen |
| st_overrun | output | 1 | Overrun seen |
| fifo_on | output | 1 | FIFO mode active |
| fill_count | output | CNT_W | Bytes queued |
| level_hit | output | 1 | Trigger level reached |
| char_timeout | output | 1 | Character timeout pending |
| txq_flush | output | 1 | Transmit flush request |

## Verification
The directed patterns each target one distinction:
- Single-byte mode against queued mode, which differ in whether a late byte replaces the held byte or is lost.
- A queue filled to the brim, with and without a read in the same cycle, which separates a dropped byte from a stored one.
- All four trigger codes, walked up to their threshold.
- Idle spans with several frame formats and tick rates, which tell a timeout at exactly four character times from one that comes a tick early or late.

A long run of random pushes, reads, breaks, status reads and control writes then mixes these events in the same cycle. This exercises the priorities among flush, break, overrun and status clearing.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned MAX_FRAME_BITS = 12;

   function automatic int unsigned trig_bytes(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

   function automatic int unsigned frame_bits(input logic [1:0] wlen,
                                              input logic par_en,
                                              input logic stop2);
      return 1 + 5 + int'(wlen) + int'(par_en) + 1 + int'(stop2);
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 din,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [AW-1:0]      wptr, rptr;
   logic [CW-1:0]      cnt_q;
   logic [DEPTH*W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] slot;
      always_ff @(posedge clk) begin
         if (push && wptr == AW'(g)) slot <= din;
      end
      assign flat[g*W +: W] = slot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   assign dout  = flat[rptr*W +: W];
   assign count = cnt_q;
endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo #(
   parameter int LIM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             kick,
   input  logic             ack,
   input  logic             tick,
   input  logic             nonempty,
   input  logic [LIM_W-1:0] limit,
   output logic             pend
);
   logic             armed;
   logic [LIM_W-1:0] cnt;
   logic             expire;

   assign expire = !kick && armed && tick && (cnt >= limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         pend  <= 1'b0;
      end else if (clr) begin
         armed <= 1'b0;
         cnt   <= '0;
         pend  <= 1'b0;
      end else begin
         if (kick) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (expire) begin
            armed <= 1'b0;
         end else if (armed && tick) begin
            cnt <= cnt + 1'b1;
         end
         if (ack)                  pend <= 1'b0;
         else if (expire && nonempty) pend <= 1'b1;
      end
   end
endmodule

// File: rtl/rx_fifo_tmo.sv
module rx_fifo_tmo #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int TMO_CHARS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_push,
   input  logic [DATA_W-1:0]           rx_byte,
   input  logic                        rx_brk,
   input  logic                        rbr_rd,
   input  logic                        lsr_rd,
   input  logic                        fcr_we,
   input  logic [7:0]                  fcr_wdata,
   input  logic                        bit_tick,
   input  logic [1:0]                  frm_wlen,
   input  logic                        frm_par_en,
   input  logic                        frm_stop2,
   output logic [DATA_W-1:0]           rbr_data,
   output logic                        st_ready,
   output logic                        st_break,
   output logic                        st_overrun,
   output logic                        fifo_on,
   output logic [$clog2(DEPTH+1)-1:0]  fill_count,
   output logic                        level_hit,
   output logic                        char_timeout,
   output logic                        txq_flush
);
   import rxq_pkg::*;

   localparam int CNT_W = $clog2(DEPTH+1);
   localparam int LIM_W = $clog2(TMO_CHARS*MAX_FRAME_BITS+1);

   if (DEPTH < 16)              begin : g_bad_depth $error("DEPTH must hold the 14-byte trigger"); end
   if ((DEPTH & (DEPTH-1)) != 0) begin : g_bad_pow2  $error("DEPTH must be a power of two"); end
   if (TMO_CHARS < 1)           begin : g_bad_tmo   $error("TMO_CHARS must be at least 1"); end

   logic              en_q;
   logic [1:0]        trig_q;
   logic [DATA_W-1:0] hold_q;
   logic              hold_v;
   logic              brk_q, ovr_q, txf_q;

   logic              inc, flush, empty, full;
   logic              do_pop, do_push, ovr_set, emptied, kick;
   logic [DATA_W-1:0] in_byte, head;
   logic [CNT_W-1:0]  cnt;
   logic [LIM_W-1:0]  limit;

   assign inc     = rx_push | rx_brk;
   assign in_byte = rx_brk ? '0 : rx_byte;
   assign flush   = fcr_we && (fcr_wdata[1] || (fcr_wdata[0] != en_q));
   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));

   assign do_pop  = !flush && en_q && rbr_rd && !empty;
   assign do_push = !flush && en_q && inc && (!full || do_pop);
   assign ovr_set = !flush && inc &&
                    (en_q ? (full && !do_pop) : (hold_v && !rbr_rd));
   assign emptied = en_q ? (do_pop && cnt == CNT_W'(1) && !do_push)
                         : (!flush && rbr_rd && hold_v && !inc);
   assign kick    = do_push || (do_pop && cnt > CNT_W'(1));
   assign limit   = LIM_W'(TMO_CHARS * frame_bits(frm_wlen, frm_par_en, frm_stop2));

   rxq_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .push(do_push), .pop(do_pop), .din(in_byte),
      .dout(head), .count(cnt)
   );

   rxq_tmo #(.LIM_W(LIM_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .kick(kick), .ack(do_pop), .tick(bit_tick),
      .nonempty(!empty), .limit(limit), .pend(char_timeout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         trig_q <= 2'b00;
         hold_q <= '0;
         hold_v <= 1'b0;
         brk_q  <= 1'b0;
         ovr_q  <= 1'b0;
         txf_q  <= 1'b0;
      end else begin
         txf_q <= fcr_we && (fcr_wdata[2] || (fcr_wdata[0] != en_q));
         if (fcr_we) begin
            en_q   <= fcr_wdata[0];
            trig_q <= fcr_wdata[7:6];
         end
         if (flush) begin
            hold_v <= 1'b0;
         end else if (!en_q) begin
            if (inc) begin
               hold_q <= in_byte;
               hold_v <= 1'b1;
            end else if (rbr_rd) begin
               hold_v <= 1'b0;
            end
         end
         if (flush)               brk_q <= 1'b0;
         else if (rx_brk)         brk_q <= 1'b1;
         else if (lsr_rd || emptied) brk_q <= 1'b0;
         if (ovr_set)             ovr_q <= 1'b1;
         else if (lsr_rd)         ovr_q <= 1'b0;
      end
   end

   assign rbr_data   = en_q ? (empty ? '0 : head) : (hold_v ? hold_q : '0);
   assign st_ready   = en_q ? !empty : hold_v;
   assign st_break   = brk_q;
   assign st_overrun = ovr_q;
   assign fifo_on    = en_q;
   assign fill_count = cnt;
   assign level_hit  = en_q ? (32'(cnt) >= trig_bytes(trig_q)) : hold_v;
   assign txq_flush  = txf_q;
endmodule

// File: rtl/rx_fifo_tmo_chk.sv
module rx_fifo_tmo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        rx_push,
   input logic [DATA_W-1:0]           rx_byte,
   input logic                        rx_brk,
   input logic                        rbr_rd,
   input logic                        lsr_rd,
   input logic                        fcr_we,
   input logic [7:0]                  fcr_wdata,
   input logic                        bit_tick,
   input logic [1:0]                  frm_wlen,
   input logic                        frm_par_en,
   input logic                        frm_stop2,
   input logic [DATA_W-1:0]           rbr_data,
   input logic                        st_ready,
   input logic                        st_break,
   input logic                        st_overrun,
   input logic                        fifo_on,
   input logic [$clog2(DEPTH+1)-1:0]  fill_count,
   input logic                        level_hit,
   input logic                        char_timeout,
   input logic                        txq_flush
);
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fill_count) <= DEPTH);

   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && 32'(fill_count) == DEPTH && rx_push && !rbr_rd && !fcr_we)
      |=> (st_overrun && 32'(fill_count) == DEPTH));

   assert_no_level_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && fill_count == '0) |-> !level_hit);

   assert_single_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_on |-> fill_count == '0);

   assert_lsr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_push && !rx_brk) |=> (!st_break && !st_overrun));

   assert_tmo_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      char_timeout |-> fill_count != '0);

   assert_flush_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fcr_we && fcr_wdata[1]) |=> (fill_count == '0 && !st_ready && !char_timeout));

   assert_mode_toggle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fcr_we && fcr_wdata[0] != fifo_on) |=> (txq_flush && !st_ready));
endmodule

bind rx_fifo_tmo rx_fifo_tmo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_fifo_tmo_bench.sv
module rx_fifo_tmo_bench;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_push = 0, rx_brk = 0, rbr_rd = 0, lsr_rd = 0, fcr_we = 0, bit_tick = 0;
   logic [7:0] rx_byte = 0, fcr_wdata = 0;
   logic [1:0] frm_wlen = 2'b11;
   logic       frm_par_en = 0, frm_stop2 = 0;
   logic [7:0] rbr_data;
   logic       st_ready, st_break, st_overrun, fifo_on, level_hit, char_timeout, txq_flush;
   logic [4:0] fill_count;

   rx_fifo_tmo u_rx_fifo_tmo (.*);

   always #2 clk = ~clk;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   byte unsigned q[$];
   byte unsigned m_hold = 0;
   bit m_holdv = 0, m_en = 0, m_brk = 0, m_ovr = 0, m_txf = 0, m_armed = 0, m_pend = 0;
   int m_trig = 0, m_tcnt = 0;

   function automatic int trig_of(int code);
      case (code) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
   endfunction

   task automatic chk(input int act, input int exp, input string tag);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int e_rbr, e_cnt, e_lvl, e_rdy;
      e_cnt = m_en ? q.size() : 0;
      e_rbr = m_en ? (q.size() > 0 ? int'(q[0]) : 0) : (m_holdv ? int'(m_hold) : 0);
      e_rdy = m_en ? int'(q.size() > 0) : int'(m_holdv);
      e_lvl = m_en ? int'(q.size() >= trig_of(m_trig)) : int'(m_holdv);
      chk(int'(rbr_data),     e_rbr,        "R2 rbr_data");
      chk(int'(fill_count),   e_cnt,        "R3 fill_count");
      chk(int'(st_ready),     e_rdy,        "R8 st_ready");
      chk(int'(st_break),     int'(m_brk),  "R6 st_break");
      chk(int'(st_overrun),   int'(m_ovr),  "R5 st_overrun");
      chk(int'(level_hit),    e_lvl,        "R4 level_hit");
      chk(int'(char_timeout), int'(m_pend), "R9 char_timeout");
      chk(int'(fifo_on),      int'(m_en),   "R12 fifo_on");
      chk(int'(txq_flush),    int'(m_txf),  "R12 txq_flush");
   endtask

   // one clock: model update from pre-edge state and current inputs
   task automatic step();
      bit inc, flush, txf, ovr_set, emptied, popped, pushed, kick;
      byte unsigned b;
      int sz0, lim;
      inc = rx_push | rx_brk;
      b = rx_brk ? 8'h00 : rx_byte;
      flush = fcr_we && (fcr_wdata[1] || (fcr_wdata[0] != m_en));
      txf = fcr_we && (fcr_wdata[2] || (fcr_wdata[0] != m_en));
      lim = 4 * (1 + 5 + int'(frm_wlen) + int'(frm_par_en) + 1 + int'(frm_stop2));
      ovr_set = 0; emptied = 0;
      @(posedge clk);
      if (flush) begin // R11
         q.delete(); m_holdv = 0; m_armed = 0; m_tcnt = 0; m_pend = 0;
      end else if (m_en) begin
         sz0 = q.size();
         popped = rbr_rd && sz0 > 0;
         if (popped) void'(q.pop_front());
         pushed = 0;
         if (inc) begin
            if (q.size() < DEPTH) begin q.push_back(b); pushed = 1; end
            else ovr_set = 1;
         end
         emptied = popped && q.size() == 0;
         kick = pushed || (popped && sz0 > 1);
         if (kick) begin m_armed = 1; m_tcnt = 0; end
         else if (m_armed && bit_tick) begin
            if (m_tcnt >= lim - 1) begin m_armed = 0; if (sz0 != 0) m_pend = 1; end
            else m_tcnt++;
         end
         if (popped) m_pend = 0; // R10
      end else begin
         ovr_set = inc && m_holdv && !rbr_rd;
         emptied = rbr_rd && m_holdv && !inc;
         if (inc) begin m_hold = b; m_holdv = 1; end
         else if (rbr_rd) m_holdv = 0;
      end
      if (flush) m_brk = 0;
      else if (rx_brk) m_brk = 1;
      else if (lsr_rd || emptied) m_brk = 0;
      if (ovr_set) m_ovr = 1;
      else if (lsr_rd) m_ovr = 0;
      if (fcr_we) begin m_en = fcr_wdata[0]; m_trig = int'(fcr_wdata[7:6]); end
      m_txf = txf;
      @(negedge clk);
      compare_all();
   endtask

   task automatic drive(input bit p, input byte unsigned d, input bit br, input bit rd,
                        input bit ls, input bit fw, input byte unsigned fd, input bit tk);
      rx_push = p; rx_byte = d; rx_brk = br; rbr_rd = rd; lsr_rd = ls;
      fcr_we = fw; fcr_wdata = fd; bit_tick = tk;
      step();
   endtask

   task automatic idle(input int n, input bit tk);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, tk);
   endtask

   initial begin
      #50000000;
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare_all(); // R1 reset values under reset
      rst_n = 1;
      @(negedge clk);
      compare_all(); // R1

      // R5 single-byte mode: hold, overrun replaces, read empties
      drive(1, 8'hA1, 0, 0, 0, 0, 0, 0);
      drive(1, 8'hB2, 0, 0, 0, 0, 0, 0);
      chk(int'(rbr_data), 8'hB2, "R5 replaced byte");
      drive(0, 0, 0, 0, 1, 0, 0, 0); // R7
      drive(1, 8'hC3, 0, 1, 0, 0, 0, 0); // read and arrive together
      drive(0, 0, 0, 1, 0, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 0, 0, 0); // empty read

      // R12 enable FIFO with trigger 4
      drive(0, 0, 0, 0, 0, 1, 8'h41, 0);
      chk(int'(txq_flush), 1, "R12 toggle pulse");
      for (int i = 0; i < 4; i++) drive(1, 8'(8'h10 + i), 0, 0, 0, 0, 0, 0); // R4
      for (int i = 4; i < 17; i++) drive(1, 8'(8'h10 + i), 0, 0, 0, 0, 0, 0); // R3 overflow
      chk(int'(st_overrun), 1, "R3 overrun on full");
      drive(1, 8'h77, 0, 1, 0, 0, 0, 0); // R3 push+read on full
      drive(0, 0, 0, 0, 1, 0, 8'h00, 0);
      for (int c = 0; c < 4; c++) begin // R4 each trigger code
         drive(0, 0, 0, 0, 0, 1, 8'(c << 6 | 1), 0);
      end
      for (int i = 0; i < 18; i++) drive(0, 0, 0, 1, 0, 0, 0, 0); // R2 drain, R8
      drive(0, 0, 1, 0, 0, 0, 0, 0); // R6 break
      drive(0, 0, 0, 1, 0, 0, 0, 0);

      // R9 timeout, 8N1 tick every cycle, then 5E2 tick every other cycle
      drive(1, 8'h5A, 0, 0, 0, 0, 0, 1);
      idle(45, 1);
      chk(int'(char_timeout), 1, "R9 timeout after 40 ticks");
      drive(0, 0, 0, 1, 0, 0, 0, 1); // R10
      frm_wlen = 2'b00; frm_par_en = 1; frm_stop2 = 1;
      drive(1, 8'h11, 0, 0, 0, 0, 0, 0);
      drive(1, 8'h22, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 40; i++) drive(0, 0, 0, 0, 0, 0, 0, i[0]);
      drive(0, 0, 0, 1, 0, 0, 0, 1); // read leaving data re-arms
      for (int i = 0; i < 80; i++) drive(0, 0, 0, 0, 0, 0, 0, i[0]);

      // R11 flush ignoring same-cycle push, R12 tx flush bit
      drive(1, 8'h99, 0, 1, 0, 1, 8'h03, 1);
      drive(0, 0, 0, 0, 0, 1, 8'h05, 0);
      drive(0, 0, 0, 0, 0, 1, 8'h00, 0);

      // random mix
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 99) < 2) begin
            frm_wlen = 2'($urandom); frm_par_en = 1'($urandom); frm_stop2 = 1'($urandom);
         end
         drive($urandom_range(0, 99) < 35, 8'($urandom), $urandom_range(0, 99) < 3,
               $urandom_range(0, 99) < (i % 1000 < 500 ? 15 : 40),
               $urandom_range(0, 99) < 10, $urandom_range(0, 99) < 2,
               8'($urandom), $urandom_range(0, 99) < 60);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule